// File: doc/BRIEF.md
# Dual DAC Register Interface

This block is the register front end for a pair of digital-to-analog channels on an 8-bit register bus. Software writes to a shared control byte and to a low and high data byte for each channel. The block turns those bytes into three things for each channel: a 12-bit output code, a range-select line and a power-enable line. The converters, buffers and references are outside the block. Only the digital side is modelled here.

The data bytes are right-justified. A write to a high byte only stages the upper code bits in a holding register. A write to a low byte is what commits a code, and it does so only while the sync control bit is 1. When sync is 0, data writes are only held. A later control write that takes sync from 0 to 1 moves both channels' held values to their outputs in the same cycle. An 8-bit mode places the low byte in the top eight code bits. An active-low clear bit for each channel forces that channel's output code to zero without losing the latched value.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset, the control register (address 0xFD) reads 0x04, the four data registers read 0x00, both output codes are 0, and all range and power outputs are 0.
- R2: A write to 0xFD stores all 8 bits, and the stored byte reads back unchanged. Bit 6 drives range[1] and bit 5 drives range[0]. Bit 1 drives power[1] and bit 0 drives power[0].
- R3: A write to a high-byte register (0xFA for channel 0, 0xFC for channel 1) never changes either output code by itself. The register reads back with its upper nibble as zero.
- R4: While control bit 2 (sync) is 1 and bit 7 (8-bit mode) is 0, a write to a low-byte register (0xF9 for channel 0, 0xFB for channel 1) sets that channel's code to {held high nibble, written byte}. The code changes in the cycle after the write.
- R5: While sync is 0, writes to the low-byte and high-byte registers leave both output codes unchanged.
- R6: A control write that changes sync from 0 to 1 loads both channels' codes from their holding registers in the same cycle. The code layout follows the bit-7 mode carried by that same write.
- R7: In 8-bit mode (bit 7 = 1), a low-byte write with sync = 1 sets the code to {byte, 4'h0}. The held high byte does not contribute.
- R8: Control bit 3 (channel 0) and bit 4 (channel 1) are active-low clears. At 0, the channel's code is forced to 0. Returning the bit to 1 restores the latched code.
- R9: Writes to unmapped addresses change no register and no output. Reads of unmapped addresses return 0x00. The read data is 0x00 whenever the read strobe is low.
- R10: A data write to one channel never alters the other channel's output code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address while bus_rd is high |
| ch_code | output | 24 | Channel codes; channel c occupies bits [12c+11:12c] |
| ch_range | output | 2 | Range select for each channel (1 = supply range) |
| ch_pwr | output | 2 | Power enable for each channel |

## Verification
The assertions assume that each bus access lasts one cycle, with the write strobe high for exactly one clock per write. They also assume that address and data are stable around the rising edge. The property that at most one write select is active relies on the address decode alone, so any address value is legal input. The bench drives the strobe, address and data only on falling edges and drops the strobe after one cycle. It always writes a high byte before the matching low byte, so every committed code is a defined combination of held bytes.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;

   localparam int unsigned CTRL_W = 8;

   // Field order is the bit order of the control byte (bit 7 first).
   typedef struct packed {
      logic       mode8;   // 1: 8-bit code layout
      logic [1:0] rng;     // range select, index = channel
      logic [1:0] clr_n;   // active-low clears, index = channel
      logic       sync;    // 1: low-byte writes commit at once
      logic [1:0] pwr;     // power enables, index = channel
   } dac_ctrl_t;

   localparam dac_ctrl_t CTRL_RESET = '{
      mode8 : 1'b0,
      rng   : 2'b00,
      clr_n : 2'b00,
      sync  : 1'b1,
      pwr   : 2'b00
   };

endpackage

// File: rtl/dac_addr_dec.sv
module dac_addr_dec #(
   parameter int unsigned AW        = 8,
   parameter int unsigned NUM_CH    = 2,
   parameter int unsigned CTRL_ADDR = 'hFD,
   parameter int unsigned DATA_BASE = 'hF9
) (
   input  logic [AW-1:0]     addr,
   output logic              sel_ctrl,
   output logic [NUM_CH-1:0] sel_lo,
   output logic [NUM_CH-1:0] sel_hi
);

   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

   if (DATA_BASE + 2 * NUM_CH > (1 << AW)) begin : g_bad_map
      $error("dac_addr_dec: data window exceeds address space");
   end

   assign sel_ctrl = (addr == CTRL_A);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [AW-1:0] LO_A = AW'(DATA_BASE + 2 * c);
      localparam logic [AW-1:0] HI_A = AW'(DATA_BASE + 2 * c + 1);
      assign sel_lo[c] = (addr == LO_A);
      assign sel_hi[c] = (addr == HI_A);
   end

endmodule

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg
   import dac_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   output dac_ctrl_t         ctrl_q,
   output logic              xfer,
   output logic              xfer_mode8
);

   dac_ctrl_t wr_val;

   assign wr_val     = dac_ctrl_t'(wdata);
   // Transfer fires only on a 0 -> 1 change of the sync bit.
   assign xfer       = wr_en && wr_val.sync && !ctrl_q.sync;
   assign xfer_mode8 = wr_val.mode8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (wr_en) begin
         ctrl_q <= wr_val;
      end
   end

   assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl_q == dac_ctrl_t'($past(wdata))));

   assert_xfer_sets_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> ctrl_q.sync);

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              sync,
   input  logic              mode8,
   input  logic              xfer,
   input  logic              xfer_mode8,
   input  logic              clr_n,
   output logic [BUS_W-1:0]  lo_q,
   output logic [CODE_W-BUS_W-1:0] hi_q,
   output logic [CODE_W-1:0] code_o
);

   localparam int unsigned HI_W = CODE_W - BUS_W;

   if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_width
      $error("dac_chan: CODE_W must lie in (BUS_W, 2*BUS_W]");
   end

   logic [CODE_W-1:0] latch_q;
   logic [CODE_W-1:0] wr_code;
   logic [CODE_W-1:0] xfer_code;

   // Layout of a committed code in either mode.
   assign wr_code   = mode8      ? {wdata, {HI_W{1'b0}}} : {hi_q, wdata};
   assign xfer_code = xfer_mode8 ? {lo_q,  {HI_W{1'b0}}} : {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi) hi_q <= wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (wr_lo && sync) begin
         latch_q <= wr_code;
      end else if (xfer) begin
         latch_q <= xfer_code;
      end
   end

   assign code_o = clr_n ? latch_q : '0;

   assert_hi_write_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo && !xfer) |=> $stable(latch_q));

   assert_lo_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && sync && !mode8) |=> (latch_q == {$past(hi_q), $past(wdata)}));

   assert_buffered_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && !xfer) |=> $stable(latch_q));

   assert_xfer_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !xfer_mode8) |=> (latch_q == {$past(hi_q), $past(lo_q)}));

   assert_mode8_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && sync && mode8) |=> (latch_q[HI_W-1:0] == '0));

endmodule

// File: rtl/dac_rd_mux.sv
module dac_rd_mux #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned HI_W   = 4,
   parameter int unsigned NUM_CH = 2
) (
   input  logic                          rd_en,
   input  logic                          sel_ctrl,
   input  logic [NUM_CH-1:0]             sel_lo,
   input  logic [NUM_CH-1:0]             sel_hi,
   input  logic [BUS_W-1:0]              ctrl_byte,
   input  logic [NUM_CH-1:0][BUS_W-1:0]  lo_bytes,
   input  logic [NUM_CH-1:0][HI_W-1:0]   hi_nibs,
   output logic [BUS_W-1:0]              rdata
);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (sel_ctrl) rdata = ctrl_byte;
         for (int c = 0; c < int'(NUM_CH); c++) begin
            if (sel_lo[c]) rdata = lo_bytes[c];
            if (sel_hi[c]) rdata = BUS_W'(hi_nibs[c]);
         end
      end
   end

endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
   import dac_regs_pkg::*;
#(
   parameter int unsigned BUS_W     = 8,
   parameter int unsigned CODE_W    = 12,
   parameter int unsigned NUM_CH    = 2,
   parameter int unsigned CTRL_ADDR = 'hFD,
   parameter int unsigned DATA_BASE = 'hF9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [BUS_W-1:0]         bus_addr,
   input  logic                     bus_wr,
   input  logic [BUS_W-1:0]         bus_wdata,
   input  logic                     bus_rd,
   output logic [BUS_W-1:0]         bus_rdata,
   output logic [NUM_CH*CODE_W-1:0] ch_code,
   output logic [NUM_CH-1:0]        ch_range,
   output logic [NUM_CH-1:0]        ch_pwr
);

   localparam int unsigned HI_W = CODE_W - BUS_W;

   if (BUS_W != CTRL_W) begin : g_bad_bus
      $error("dual_dac_regs: bus width must match control byte");
   end
   if (NUM_CH != 2) begin : g_bad_ch
      $error("dual_dac_regs: control layout holds exactly two channels");
   end
   if (CODE_W <= BUS_W || CODE_W > 2 * BUS_W) begin : g_bad_code
      $error("dual_dac_regs: code width out of range");
   end

   logic                           sel_ctrl;
   logic [NUM_CH-1:0]              sel_lo;
   logic [NUM_CH-1:0]              sel_hi;
   logic                           wr_ctrl;
   logic [NUM_CH-1:0]              wr_lo;
   logic [NUM_CH-1:0]              wr_hi;
   dac_ctrl_t                      ctrl_q;
   logic                           xfer;
   logic                           xfer_mode8;
   logic [NUM_CH-1:0][BUS_W-1:0]   lo_bytes;
   logic [NUM_CH-1:0][HI_W-1:0]    hi_nibs;

   dac_addr_dec #(
      .AW(BUS_W), .NUM_CH(NUM_CH), .CTRL_ADDR(CTRL_ADDR), .DATA_BASE(DATA_BASE)
   ) dec_i (
      .addr(bus_addr), .sel_ctrl(sel_ctrl), .sel_lo(sel_lo), .sel_hi(sel_hi)
   );

   assign wr_ctrl = bus_wr && sel_ctrl;
   assign wr_lo   = {NUM_CH{bus_wr}} & sel_lo;
   assign wr_hi   = {NUM_CH{bus_wr}} & sel_hi;

   dac_ctrl_reg ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
      .ctrl_q(ctrl_q), .xfer(xfer), .xfer_mode8(xfer_mode8)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dac_chan #(.BUS_W(BUS_W), .CODE_W(CODE_W)) chan_i (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]), .wdata(bus_wdata),
         .sync(ctrl_q.sync), .mode8(ctrl_q.mode8),
         .xfer(xfer), .xfer_mode8(xfer_mode8),
         .clr_n(ctrl_q.clr_n[c]),
         .lo_q(lo_bytes[c]), .hi_q(hi_nibs[c]),
         .code_o(ch_code[c*CODE_W +: CODE_W])
      );
      assign ch_range[c] = ctrl_q.rng[c];
      assign ch_pwr[c]   = ctrl_q.pwr[c];
   end

   dac_rd_mux #(.BUS_W(BUS_W), .HI_W(HI_W), .NUM_CH(NUM_CH)) rd_i (
      .rd_en(bus_rd), .sel_ctrl(sel_ctrl), .sel_lo(sel_lo), .sel_hi(sel_hi),
      .ctrl_byte(BUS_W'(ctrl_q)), .lo_bytes(lo_bytes), .hi_nibs(hi_nibs),
      .rdata(bus_rdata)
   );

   assert_wr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_ctrl, wr_lo, wr_hi}));

   assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !sel_ctrl && (sel_lo == '0) && (sel_hi == '0)) |=>
         ($stable(ctrl_q) && $stable(lo_bytes) && $stable(hi_nibs) && $stable(ch_code)));

endmodule

// File: tb/dual_dac_regs_tb_top.sv
`timescale 1ns/1ps
module dual_dac_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [23:0] ch_code;
   logic [1:0]  ch_range;
   logic [1:0]  ch_pwr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dual_dac_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ch_code(ch_code), .ch_range(ch_range), .ch_pwr(ch_pwr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(req, 32'(bus_rdata), 32'(exp));
      bus_rd = 1'b0;
   endtask

   task automatic codes_chk(input string req, input logic [11:0] c0, input logic [11:0] c1);
      chk({req, " ch0"}, 32'(ch_code[11:0]),  32'(c0));
      chk({req, " ch1"}, 32'(ch_code[23:12]), 32'(c1));
   endtask

   task automatic t_reset;   // R1
      rd_chk("R1 ctrl", 8'hFD, 8'h04);
      rd_chk("R1 lo0",  8'hF9, 8'h00);
      rd_chk("R1 hi0",  8'hFA, 8'h00);
      rd_chk("R1 lo1",  8'hFB, 8'h00);
      rd_chk("R1 hi1",  8'hFC, 8'h00);
      codes_chk("R1 code", 12'h000, 12'h000);
      chk("R1 range", 32'(ch_range), 32'h0);
      chk("R1 pwr",   32'(ch_pwr),   32'h0);
   endtask

   task automatic t_ctrl;    // R2
      wr(8'hFD, 8'h63);
      chk("R2 range 0x63", 32'(ch_range), 32'h3);
      chk("R2 pwr 0x63",   32'(ch_pwr),   32'h3);
      rd_chk("R2 readback 0x63", 8'hFD, 8'h63);
      wr(8'hFD, 8'h5D);
      chk("R2 range 0x5D", 32'(ch_range), 32'h2);
      chk("R2 pwr 0x5D",   32'(ch_pwr),   32'h1);
      rd_chk("R2 readback 0x5D", 8'hFD, 8'h5D);
   endtask

   task automatic t_hi_only; // R3
      wr(8'hFA, 8'hA5);
      codes_chk("R3 hi write no commit", 12'h000, 12'h000);
      rd_chk("R3 hi nibble readback", 8'hFA, 8'h05);
   endtask

   task automatic t_immediate; // R4 R10
      wr(8'hF9, 8'h3C);
      codes_chk("R4 R10 ch0 commit", 12'h53C, 12'h000);
      wr(8'hFC, 8'h0F);
      wr(8'hFB, 8'hFF);
      codes_chk("R4 R10 ch1 commit", 12'h53C, 12'hFFF);
   endtask

   task automatic t_buffered; // R5 R6
      wr(8'hFD, 8'h1B);
      wr(8'hFA, 8'h01);
      wr(8'hF9, 8'h23);
      wr(8'hFC, 8'h0E);
      wr(8'hFB, 8'h45);
      codes_chk("R5 held while sync 0", 12'h53C, 12'hFFF);
      wr(8'hFD, 8'h1F);
      codes_chk("R6 joint transfer", 12'h123, 12'hE45);
   endtask

   task automatic t_mode8;   // R7
      wr(8'hFD, 8'h9F);
      wr(8'hFA, 8'h0B);
      codes_chk("R7 hi ignored before lo", 12'h123, 12'hE45);
      wr(8'hF9, 8'h9A);
      codes_chk("R7 8-bit layout", 12'h9A0, 12'hE45);
   endtask

   task automatic t_clear;   // R8
      wr(8'hFD, 8'h97);
      codes_chk("R8 clear ch0", 12'h000, 12'hE45);
      wr(8'hFD, 8'h8F);
      codes_chk("R8 clear ch1", 12'h9A0, 12'h000);
      wr(8'hFD, 8'h9F);
      codes_chk("R8 restore", 12'h9A0, 12'hE45);
   endtask

   task automatic t_unmapped; // R9
      wr(8'hF8, 8'hFF);
      wr(8'hFE, 8'h00);
      wr(8'h00, 8'h55);
      codes_chk("R9 unmapped write", 12'h9A0, 12'hE45);
      rd_chk("R9 ctrl kept", 8'hFD, 8'h9F);
      rd_chk("R9 lo0 kept",  8'hF9, 8'h9A);
      rd_chk("R9 hi0 kept",  8'hFA, 8'h0B);
      rd_chk("R9 lo1 kept",  8'hFB, 8'h45);
      rd_chk("R9 hi1 kept",  8'hFC, 8'h0E);
      rd_chk("R9 read 0xF8", 8'hF8, 8'h00);
      rd_chk("R9 read 0xFE", 8'hFE, 8'h00);
      @(negedge clk);
      bus_addr = 8'hFD;
      #1;
      chk("R9 idle read data", 32'(bus_rdata), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_hi_only();
      t_immediate();
      t_buffered();
      t_mode8();
      t_clear();
      t_unmapped();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule